// File: doc/BRIEF.md
# Serial Transmit Channel with Clear-to-Send Gating and Request-to-Send Turnaround

This block is one asynchronous serial transmit channel. Software (or a bus adapter outside this block) writes a character into a single-entry holding stage. A shifter takes the character from there and frames it: a start bit, 5 to 8 data bits least significant first, an optional ninth bit and a stop period. The ninth bit can be a parity bit, a fixed level, or an address/data marker given per character. Bit timing comes from a 16x clock enable. Each data bit lasts 16 enables, and the stop period is set in single-enable steps from 16 to 32.

Flow control works in two directions. With gating enabled, an active-low clear-to-send input stops a new character from starting, but a character already on the line always finishes. An active-low request-to-send output is set and cleared by command pulses. It can also be cleared automatically once the last queued character has fully left, which suits half-duplex line-driver turnaround. A break command holds the line at space. Any character written during the break is discarded when the break ends.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset `txd` is high (mark). Whenever `tx_empty` is high, `txd` is high. While `tx_en` is low no new character starts; a written character waits in the holding stage.
- R2: A character starts with one low start bit, then `5 + cfg_len` data bits least significant bit first. With 16 enables per bit, each bit lasts 16 `tick16` pulses.
- R3: `cfg_parity` codes select the bit after the data: 0 none, 1 even (the data bits plus this bit hold an even number of ones), 2 odd, 3 always 0, 4 always 1; codes 6 and 7 behave as 0.
- R4: `cfg_parity` code 5 sends the `wr_addr_bit` value that was captured with that character's write as the bit after the data.
- R5: After the last frame bit, the line stays high for `cfg_stop_ticks` enables, with values below 16 treated as 16 and above 32 as 32. `tx_empty` rises when that count completes and nothing is queued. With one enable per clock, `tx_empty` is seen high exactly 16·(bits incl. start and parity) + stop cycles after the start bit first appears.
- R6: `tx_rdy` is high when the holding stage is empty. A write with `tx_rdy` high is taken and drops `tx_rdy` on the next cycle. A write while `tx_rdy` is low is ignored. Queued characters are sent in write order.
- R7: With `cfg_cts_en` high and `cts_n` high, no character starts. `cts_n` rising during a character does not disturb it. With `cfg_cts_en` low, `cts_n` has no effect.
- R8: A `brk_start` pulse drives `txd` low from the next cycle and aborts any character in progress. A `brk_stop` pulse during a break returns `txd` high, empties the holding stage, and leaves `tx_empty` high.
- R9: With `cfg_auto_rts` high, `rts_n` goes high in the same cycle that `tx_empty` rises after the final character. It stays low while further characters are queued.
- R10: `rts_n` resets high. A `rts_assert` pulse drives it low and a `rts_negate` pulse drives it high; assert wins when both arrive together. With `cfg_auto_rts` low it does not change on its own.
- R11: Frame timing advances only on `tick16`: with no enables a started character holds its current bit, and with sparse enables each bit stretches accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate enable |
| tx_en | input | 1 | Transmitter enable |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_parity | input | 3 | Ninth-bit mode code |
| cfg_stop_ticks | input | 6 | Stop period in enables (clamped 16..32) |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| cfg_auto_rts | input | 1 | Enable automatic request-to-send negation |
| rts_assert | input | 1 | Pulse: drive `rts_n` low |
| rts_negate | input | 1 | Pulse: drive `rts_n` high |
| brk_start | input | 1 | Pulse: begin break |
| brk_stop | input | 1 | Pulse: end break |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Character to send |
| wr_addr_bit | input | 1 | Per-character ninth bit for code 5 |
| txd | output | 1 | Serial line, high is mark |
| tx_rdy | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Nothing queued, in flight or in break |
| rts_n | output | 1 | Request to send, active low |

## Verification
The assertions check these rules on every cycle: idle means mark, a disabled or clear-to-send-blocked shifter stays idle, an accepted write fills the holding stage, and the break start and release effects. The request-to-send rules are checked the same way: negation coincides with the rise of `tx_empty`, and an assert pulse wins. The bench scenarios are needed to show bit order, the ninth-bit value under each code, the stop-length clamping as exact frame durations, and that a write into a full stage really disappears. They also show that a character written during a break never appears, and that sparse or stalled enables stretch or freeze a frame.

// File: rtl/uart_tx_pkg.sv
// Shared types for the serial transmit channel.
package uart_tx_pkg;
    // Ninth-bit selection codes.
    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_SPACE = 3'd3,
        PAR_MARK  = 3'd4,
        PAR_ADDR  = 3'd5
    } par_mode_e;

    // Shifter phases.
    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_DATA = 2'd1,
        SH_STOP = 2'd2
    } sh_phase_e;
endpackage

// File: rtl/uart_tx_hold.sv
// Single-entry holding stage. Accepts a write only when empty; the shifter
// empties it with take, a break release empties it with flush.
// Assumes take is raised only while full.
module uart_tx_hold #(
    parameter int DATA_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                wr_bit9,
    input  logic                take,
    input  logic                flush,
    output logic                full,
    output logic [DATA_MAX-1:0] data,
    output logic                bit9
);
    // Occupancy flag and stored character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            bit9 <= 1'b0;
        end else if (flush || take) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            data <= wr_data;
            bit9 <= wr_bit9;
        end
    end
endmodule

// File: rtl/uart_tx_shift.sv
// Frame builder and shifter. On load it latches a framed character
// (start, data LSB first, optional ninth bit) plus the clamped stop
// length, then steps one bit per TICKS_PER_BIT enables and holds mark for
// the stop period. done pulses in the cycle the stop period ends.
// Assumes DATA_MAX >= 5 and load only while idle.
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int DATA_MAX      = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   tick,
    input  logic                                   load,
    input  logic                                   abort,
    input  logic [DATA_MAX-1:0]                    ld_data,
    input  logic [1:0]                             ld_len,
    input  logic [2:0]                             ld_par,
    input  logic                                   ld_bit9,
    input  logic [$clog2(2*TICKS_PER_BIT+1)-1:0]   ld_stop,
    output logic                                   busy,
    output logic                                   line,
    output logic                                   done
);
    localparam int FW   = DATA_MAX + 2;
    localparam int CW   = $clog2(TICKS_PER_BIT);
    localparam int SW   = $clog2(2*TICKS_PER_BIT+1);
    localparam int NW   = $clog2(FW+1);
    localparam logic [CW-1:0] TICK_LAST = CW'(TICKS_PER_BIT-1);
    localparam logic [SW-1:0] STOP_MIN  = SW'(TICKS_PER_BIT);
    localparam logic [SW-1:0] STOP_MAX  = SW'(2*TICKS_PER_BIT);

    sh_phase_e        phase;
    logic [FW-1:0]    shreg, frame_nx;
    logic [NW-1:0]    bits_left, nbits_nx;
    logic [CW-1:0]    tick_cnt;
    logic [SW-1:0]    stop_cnt, stop_len, stop_nx;

    // Build the frame image and stop length for the character being loaded.
    always_comb begin
        int   nd;
        logic acc, pbit, has_p;
        nd = DATA_MAX - 3 + int'(ld_len);
        frame_nx = '1;
        frame_nx[0] = 1'b0;
        acc = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < nd) begin
                frame_nx[i+1] = ld_data[i];
                acc = acc ^ ld_data[i];
            end
        end
        has_p = 1'b1;
        pbit  = 1'b0;
        case (ld_par)
            PAR_EVEN:  pbit = acc;
            PAR_ODD:   pbit = ~acc;
            PAR_SPACE: pbit = 1'b0;
            PAR_MARK:  pbit = 1'b1;
            PAR_ADDR:  pbit = ld_bit9;
            default:   has_p = 1'b0;
        endcase
        if (has_p) frame_nx[nd+1] = pbit;
        nbits_nx = NW'(nd + 1 + int'(has_p));
        if (ld_stop < STOP_MIN)      stop_nx = STOP_MIN;
        else if (ld_stop > STOP_MAX) stop_nx = STOP_MAX;
        else                         stop_nx = ld_stop;
    end

    // Phase sequencing, bit stepping and stop counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= SH_IDLE;
            shreg     <= '1;
            bits_left <= '0;
            tick_cnt  <= '0;
            stop_cnt  <= '0;
            stop_len  <= STOP_MIN;
        end else if (abort) begin
            phase <= SH_IDLE;
        end else begin
            case (phase)
                SH_IDLE: if (load) begin
                    phase     <= SH_DATA;
                    shreg     <= frame_nx;
                    bits_left <= nbits_nx;
                    stop_len  <= stop_nx;
                    tick_cnt  <= '0;
                end
                SH_DATA: if (tick) begin
                    if (tick_cnt == TICK_LAST) begin
                        tick_cnt <= '0;
                        shreg    <= {1'b1, shreg[FW-1:1]};
                        if (bits_left == NW'(1)) begin
                            phase    <= SH_STOP;
                            stop_cnt <= '0;
                        end else begin
                            bits_left <= bits_left - NW'(1);
                        end
                    end else begin
                        tick_cnt <= tick_cnt + CW'(1);
                    end
                end
                SH_STOP: if (tick) begin
                    if (stop_cnt == stop_len - SW'(1)) phase <= SH_IDLE;
                    else                               stop_cnt <= stop_cnt + SW'(1);
                end
                default: phase <= SH_IDLE;
            endcase
        end
    end

    assign busy = (phase != SH_IDLE);
    assign line = (phase == SH_DATA) ? shreg[0] : 1'b1;
    assign done = (phase == SH_STOP) && tick && !abort &&
                  (stop_cnt == stop_len - SW'(1));
endmodule

// File: rtl/uart_tx_rts.sv
// Request-to-send register. Command pulses set or clear it (assert wins);
// with auto mode on, the final character leaving clears it.
module uart_tx_rts (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_assert,
    input  logic rts_negate,
    input  logic auto_en,
    input  logic last_done,
    output logic rts_n
);
    // Active-low output state with command priority over auto clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rts_n <= 1'b1;
        else if (rts_assert)            rts_n <= 1'b0;
        else if (rts_negate)            rts_n <= 1'b1;
        else if (auto_en && last_done)  rts_n <= 1'b1;
    end
endmodule

// File: rtl/uart_tx_flow.sv
// Transmit channel top: holding stage, shifter, break control, start gating
// by enable and clear-to-send, and request-to-send control.
// Assumes tick16 is a single-cycle enable at 16x the bit rate.
module uart_tx_flow #(
    parameter int TICKS_PER_BIT = 16,
    parameter int DATA_MAX      = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  tick16,
    input  logic                                  tx_en,
    input  logic [1:0]                            cfg_len,
    input  logic [2:0]                            cfg_parity,
    input  logic [$clog2(2*TICKS_PER_BIT+1)-1:0]  cfg_stop_ticks,
    input  logic                                  cfg_cts_en,
    input  logic                                  cts_n,
    input  logic                                  cfg_auto_rts,
    input  logic                                  rts_assert,
    input  logic                                  rts_negate,
    input  logic                                  brk_start,
    input  logic                                  brk_stop,
    input  logic                                  wr_valid,
    input  logic [DATA_MAX-1:0]                   wr_data,
    input  logic                                  wr_addr_bit,
    output logic                                  txd,
    output logic                                  tx_rdy,
    output logic                                  tx_empty,
    output logic                                  rts_n
);
    logic                hold_full, hold_bit9, busy, line, sh_done;
    logic                brk_q, start_ok, flush;
    logic [DATA_MAX-1:0] hold_data;

    // Break state: start pulse sets, stop pulse clears.
    always_ff @(posedge clk) begin
        if (!rst_n)         brk_q <= 1'b0;
        else if (brk_start) brk_q <= 1'b1;
        else if (brk_stop)  brk_q <= 1'b0;
    end

    assign flush    = brk_stop && brk_q && !brk_start;
    assign start_ok = !busy && hold_full && tx_en && !brk_q &&
                      !(cfg_cts_en && cts_n);

    uart_tx_hold #(.DATA_MAX(DATA_MAX)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_addr_bit),
        .take(start_ok), .flush(flush),
        .full(hold_full), .data(hold_data), .bit9(hold_bit9)
    );

    uart_tx_shift #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_MAX(DATA_MAX)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .load(start_ok), .abort(brk_start),
        .ld_data(hold_data), .ld_len(cfg_len), .ld_par(cfg_parity),
        .ld_bit9(hold_bit9), .ld_stop(cfg_stop_ticks),
        .busy(busy), .line(line), .done(sh_done)
    );

    uart_tx_rts u_rts (
        .clk(clk), .rst_n(rst_n),
        .rts_assert(rts_assert), .rts_negate(rts_negate),
        .auto_en(cfg_auto_rts), .last_done(sh_done && !hold_full),
        .rts_n(rts_n)
    );

    assign txd      = brk_q ? 1'b0 : line;
    assign tx_rdy   = !hold_full;
    assign tx_empty = !hold_full && !busy && !brk_q;
endmodule

// File: rtl/uart_tx_flow_chk.sv
// Property checker for uart_tx_flow, attached by bind below.
module uart_tx_flow_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic cfg_cts_en,
    input logic cts_n,
    input logic cfg_auto_rts,
    input logic rts_assert,
    input logic brk_start,
    input logic brk_stop,
    input logic wr_valid,
    input logic txd,
    input logic tx_rdy,
    input logic tx_empty,
    input logic rts_n,
    input logic busy,
    input logic brk_q
);
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);                                               // R1
    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_en) |=> !busy);                                    // R1
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy && wr_valid && !(brk_stop && brk_q)) |=> !tx_rdy);      // R6
    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_cts_en && cts_n) |=> !busy);                       // R7
    AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && brk_start) |-> !txd);                             // R8
    AST_BREAK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && brk_q && brk_stop && !brk_start) |-> (txd && tx_empty)); // R8
    AST_AUTO_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_empty) && $past(rst_n && cfg_auto_rts && !rts_assert && !brk_q))
        |-> rts_n);                                                      // R9
    AST_RTS_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rts_assert) |-> !rts_n);                          // R10
endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_cts_en(cfg_cts_en),
    .cts_n(cts_n), .cfg_auto_rts(cfg_auto_rts), .rts_assert(rts_assert),
    .brk_start(brk_start), .brk_stop(brk_stop), .wr_valid(wr_valid),
    .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty), .rts_n(rts_n),
    .busy(busy), .brk_q(brk_q)
);

// File: tb/uart_tx_flow_bench.sv
module uart_tx_flow_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TPB = 16;
    localparam int DW  = 8;
    localparam int SW  = $clog2(2*TPB+1);

    logic          clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, tx_en = 1'b0;
    logic [1:0]    cfg_len = 2'd3;
    logic [2:0]    cfg_parity = 3'd0;
    logic [SW-1:0] cfg_stop_ticks = SW'(16);
    logic          cfg_cts_en = 1'b0, cts_n = 1'b0, cfg_auto_rts = 1'b0;
    logic          rts_assert = 1'b0, rts_negate = 1'b0;
    logic          brk_start = 1'b0, brk_stop = 1'b0;
    logic          wr_valid = 1'b0, wr_addr_bit = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          txd, tx_rdy, tx_empty, rts_n;

    int     n_tests = 0, n_fail = 0, tick_p = 1, tcnt = 0;
    longint cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_flow u_uart_tx_flow (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_stop_ticks(cfg_stop_ticks),
        .cfg_cts_en(cfg_cts_en), .cts_n(cts_n), .cfg_auto_rts(cfg_auto_rts),
        .rts_assert(rts_assert), .rts_negate(rts_negate),
        .brk_start(brk_start), .brk_stop(brk_stop),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_addr_bit(wr_addr_bit),
        .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty), .rts_n(rts_n)
    );

    // Cycle counter and enable generator (one pulse every tick_p clocks, none if 0).
    initial forever begin
        @(posedge clk);
        cyc++;
        tick16 <= (tick_p != 0) && (tcnt == 0);
        tcnt = (tick_p == 0 || tcnt + 1 >= tick_p) ? 0 : tcnt + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clamp_stop(input int s);
        return (s < TPB) ? TPB : (s > 2*TPB) ? 2*TPB : s;
    endfunction

    // Expected frame: start, data LSB first, optional ninth bit, then mark.
    function automatic void mk_frame(input logic [7:0] d, input int len, input int mode,
                                     input bit b9, output logic [10:0] f, output int n);
        int nd = 5 + len;
        bit acc = 0, pb = 0, has = 1;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[i+1] = d[i];
            acc ^= d[i];
        end
        case (mode)
            1: pb = acc;
            2: pb = !acc;
            3: pb = 0;
            4: pb = 1;
            5: pb = b9;
            default: has = 0;
        endcase
        if (has) f[nd+1] = pb;
        n = 1 + nd + int'(has);
    endfunction

    function automatic bit frame_match(input logic [10:0] g, input logic [10:0] f, input int n);
        for (int k = 0; k <= n; k++) if (g[k] !== f[k]) return 0;
        return 1;
    endfunction

    task automatic write_char(input logic [7:0] d, input bit b9);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_addr_bit = b9;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic set_cfg(input int len, input int mode, input int stop);
        cfg_len = 2'(len); cfg_parity = 3'(mode); cfg_stop_ticks = SW'(stop);
    endtask

    // Sample a frame of n bits plus the first stop bit; optionally time it.
    task automatic recv_frame(input int p, input int n, output logic [10:0] got,
                              output longint t, input bit measure);
        int w = 0;
        longint c0;
        got = '1; t = -1;
        while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
        if (txd !== 1'b0) begin got = '0; return; end
        c0 = cyc;
        repeat (8*p) @(negedge clk);
        for (int k = 0; k <= n; k++) begin
            got[k] = txd;
            if (k < n) repeat (16*p) @(negedge clk);
        end
        if (measure) begin
            w = 0;
            while (tx_empty !== 1'b1 && w < 4000) begin @(negedge clk); w++; end
            t = cyc - c0;
        end
    endtask

    task automatic count_low(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
    endtask

    task automatic pulse_brk(input bit start);
        @(negedge clk);
        if (start) brk_start = 1'b1; else brk_stop = 1'b1;
        @(negedge clk);
        brk_start = 1'b0; brk_stop = 1'b0;
    endtask

    task automatic pulse_rts(input bit a, input bit ng);
        @(negedge clk);
        rts_assert = a; rts_negate = ng;
        @(negedge clk);
        rts_assert = 1'b0; rts_negate = 1'b0;
    endtask

    // Send one character with the current settings and check bits and duration.
    task automatic send_and_check(input logic [7:0] d, input int len, input int mode,
                                  input bit b9, input int stop, input string tag);
        logic [10:0] f, g;
        int n;
        longint t;
        mk_frame(d, len, mode, b9, f, n);
        set_cfg(len, mode, stop);
        write_char(d, b9);
        recv_frame(1, n, g, t, 1'b1);
        check(frame_match(g, f, n), tag, longint'(g), longint'(f));
        check(t == longint'(16*n + clamp_stop(stop)), "R5 frame duration", t,
              longint'(16*n + clamp_stop(stop)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [10:0] f, g, f2, g2;
        int n, n2, lows, rts_hi;
        longint t;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R6, R10: reset state
        check(txd === 1'b1, "R1 reset txd", txd, 1);
        check(tx_rdy === 1'b1 && tx_empty === 1'b1, "R6 reset flags", {tx_rdy, tx_empty}, 3);
        check(rts_n === 1'b1, "R10 reset rts_n", rts_n, 1);

        // R1: disabled transmitter holds the character
        set_cfg(3, 0, 16);
        write_char(8'h5A, 0);
        count_low(60, lows);
        check(lows == 0 && tx_rdy === 1'b0, "R1 disabled no start", lows, 0);
        tx_en = 1'b1;
        mk_frame(8'h5A, 3, 0, 0, f, n);
        recv_frame(1, n, g, t, 1'b1);
        check(frame_match(g, f, n), "R1 frame after enable", g, f);

        // R6: queued order, write into a full stage ignored
        mk_frame(8'h31, 3, 0, 0, f, n);
        mk_frame(8'hC4, 3, 0, 0, f2, n2);
        write_char(8'h31, 0);
        fork
            recv_frame(1, n, g, t, 1'b0);
            begin
                write_char(8'hC4, 0);
                check(tx_rdy === 1'b0, "R6 tx_rdy low when full", tx_rdy, 0);
                write_char(8'hFF, 0);
            end
        join
        check(frame_match(g, f, n), "R6 first char", g, f);
        recv_frame(1, n2, g2, t, 1'b0);
        check(frame_match(g2, f2, n2), "R6 second char", g2, f2);
        count_low(300, lows);
        check(lows == 0 && tx_empty === 1'b1, "R6 ignored write absent", lows, 0);

        // R7: clear-to-send gating
        cfg_cts_en = 1'b1; cts_n = 1'b1;
        mk_frame(8'h96, 3, 0, 0, f, n);
        mk_frame(8'h0F, 3, 0, 0, f2, n2);
        write_char(8'h96, 0);
        count_low(100, lows);
        check(lows == 0 && tx_rdy === 1'b0, "R7 blocked by cts_n", lows, 0);
        cts_n = 1'b0;
        fork
            recv_frame(1, n, g, t, 1'b0);
            begin
                write_char(8'h0F, 0);
                repeat (30) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        check(frame_match(g, f, n), "R7 in-flight char completes", g, f);
        count_low(150, lows);
        check(lows == 0 && tx_rdy === 1'b0, "R7 next char held", lows, 0);
        cts_n = 1'b0;
        recv_frame(1, n2, g2, t, 1'b0);
        check(frame_match(g2, f2, n2), "R7 held char sent", g2, f2);
        cfg_cts_en = 1'b0; cts_n = 1'b1;
        send_and_check(8'hA3, 3, 0, 0, 16, "R7 cts ignored when off");
        cts_n = 1'b0;

        // R8: break
        set_cfg(3, 0, 16);
        write_char(8'h55, 0);
        repeat (40) @(negedge clk);
        pulse_brk(1);
        check(txd === 1'b0, "R8 break drives space", txd, 0);
        count_low(60, lows);
        check(lows == 60, "R8 break held", lows, 60);
        write_char(8'h77, 0);
        check(tx_rdy === 1'b0, "R8 write during break queued", tx_rdy, 0);
        pulse_brk(0);
        check(txd === 1'b1 && tx_rdy === 1'b1 && tx_empty === 1'b1, "R8 break release",
              {txd, tx_rdy, tx_empty}, 7);
        count_low(300, lows);
        check(lows == 0, "R8 char from break dropped", lows, 0);

        // R10: manual request-to-send
        pulse_rts(1, 0);
        check(rts_n === 1'b0, "R10 assert", rts_n, 0);
        send_and_check(8'h3C, 3, 0, 0, 16, "R2 frame 8N");
        check(rts_n === 1'b0, "R10 no auto when off", rts_n, 0);
        pulse_rts(0, 1);
        check(rts_n === 1'b1, "R10 negate", rts_n, 1);
        pulse_rts(1, 1);
        check(rts_n === 1'b0, "R10 assert priority", rts_n, 0);

        // R9: automatic negation after final character
        cfg_auto_rts = 1'b1;
        write_char(8'h81, 0);
        write_char(8'h18, 0);
        rts_hi = 0;
        for (int i = 0; i < 4000 && tx_empty !== 1'b1; i++) begin
            if (rts_n !== 1'b0) rts_hi++;
            @(negedge clk);
        end
        check(rts_hi == 0, "R9 rts held while queued", rts_hi, 0);
        check(tx_empty === 1'b1 && rts_n === 1'b1, "R9 rts negated at empty", rts_n, 1);
        cfg_auto_rts = 1'b0;

        // R4: per-character ninth bit; R3: fixed and parity codes
        send_and_check(8'h12, 3, 5, 1, 16, "R4 addr bit one");
        send_and_check(8'h12, 3, 5, 0, 16, "R4 addr bit zero");
        send_and_check(8'h07, 2, 1, 0, 16, "R3 even parity");
        send_and_check(8'h07, 2, 2, 0, 16, "R3 odd parity");
        send_and_check(8'hFF, 0, 3, 1, 16, "R3 forced zero");
        send_and_check(8'h00, 1, 4, 0, 16, "R3 forced one");
        send_and_check(8'hE5, 3, 7, 1, 16, "R3 unused code as none");

        // R5: stop length bounds
        send_and_check(8'h2B, 0, 0, 0, 5, "R5 short stop clamped");
        send_and_check(8'h2B, 0, 0, 0, 40, "R5 long stop clamped");
        send_and_check(8'h2B, 0, 0, 0, 25, "R5 fractional stop");

        // R11: sparse and stalled enables
        tick_p = 3;
        set_cfg(2, 1, 24);
        mk_frame(8'h4D, 2, 1, 0, f, n);
        write_char(8'h4D, 0);
        recv_frame(3, n, g, t, 1'b0);
        check(frame_match(g, f, n), "R11 sparse enables", g, f);
        repeat (200) @(negedge clk);
        tick_p = 0;
        write_char(8'h99, 0);
        repeat (200) @(negedge clk);
        check(txd === 1'b0 && tx_empty === 1'b0, "R11 stalled without enables",
              {txd, tx_empty}, 0);
        tick_p = 1;
        for (int i = 0; i < 4000 && tx_empty !== 1'b1; i++) @(negedge clk);
        check(txd === 1'b1 && tx_empty === 1'b1, "R11 resumes with enables", txd, 1);

        // R2, R3, R4, R5: random characters and settings
        for (int it = 0; it < 30; it++) begin
            int len = $urandom_range(0, 3);
            int mode = $urandom_range(0, 5);
            int stop = $urandom_range(0, 39);
            logic [7:0] d = 8'($urandom);
            bit b9 = 1'($urandom);
            send_and_check(d, len, mode, b9, stop,
                           (mode == 0) ? "R2 random frame" :
                           (mode == 5) ? "R4 random frame" : "R3 random frame");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule